// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns bytes written by a host into asynchronous serial characters. A byte enters a single holding register. When the serializer is idle, the byte moves into it and goes out on the line in this order: a start bit at logic 0, the data bits least significant first, an optional parity bit, and a stop period at logic 1. A separate clock-enable pulse sets the bit timing. It arrives at sixteen times the bit rate, so every bit lasts sixteen pulses.

A seven-bit line-control word sets the character format at run time. It chooses the data length, the stop length, parity generation and polarity, constant parity, and a break override that holds the line low. Two flags report progress. One shows the holding register is free to take a byte. The other shows the serializer has nothing in flight. The host can therefore refill the holding register while a character is still being shifted out.

Top module: `serial_tx_core`

## Requirements
- R1: After reset, with no character pending, `txd` is 1 and both `hold_empty` and `shift_empty` are 1.
- R2: `line_ctrl[1:0]` codes 00, 01, 10 and 11 send 5, 6, 7 and 8 data bits. A frame is a start bit at 0, then the data bits least significant first. Each bit lasts 16 `baud_x16` pulses. Data bits above the selected length are not sent.
- R3: With `line_ctrl[2]`=0 the stop period is 16 pulses at 1. With `line_ctrl[2]`=1 it is 24 pulses for 5-bit characters and 32 pulses for 6-, 7- and 8-bit characters.
- R4: With `line_ctrl[3]`=1 one parity bit follows the data. With `line_ctrl[3]`=0 no parity bit is sent, and `line_ctrl[4]` and `line_ctrl[5]` have no effect on the waveform.
- R5: With parity on and `line_ctrl[5]`=0, `line_ctrl[4]`=0 makes the data bits plus the parity bit hold an odd count of ones, and `line_ctrl[4]`=1 makes the count even.
- R6: With `line_ctrl[3]` and `line_ctrl[5]` both 1, the parity bit is the constant inverse of `line_ctrl[4]`.
- R7: While `line_ctrl[6]` is 1, `txd` is 0. When it clears, `txd` returns to the level the frame logic drives.
- R8: `hold_empty` is 0 from the clock edge that takes a write. It returns to 1 on the edge where the pending byte moves into the serializer, one clock after the serializer becomes idle.
- R9: `shift_empty` goes to 0 on the edge that moves a byte into the serializer. It stays 0 until the last pulse of the stop period.
- R10: A write while the holding register is full replaces the pending byte. Only the last byte written goes out after the current frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | One-cycle strobe that writes the holding register |
| wr_data | input | 8 | Byte to transmit |
| baud_x16 | input | 1 | Clock enable at sixteen times the bit rate |
| line_ctrl | input | 7 | Format: [1:0] length, [2] long stop, [3] parity on, [4] even, [5] constant parity, [6] break |
| txd | output | 1 | Serial output, 1 = mark |
| hold_empty | output | 1 | Holding register can take a byte |
| shift_empty | output | 1 | Serializer idle |

## Verification
The hardest state to reach is a holding register that is full while a frame is still going out. Only then can an overwrite happen, and only then does the next frame follow from a byte that was queued earlier. The bench reaches this state by writing the second byte in the same cycle as the first transfer, and the third byte one cycle later. It then drives the baud pulses through two complete frames and compares every pulse of the waveform, so that both the replaced byte and the gap between the frames are visible.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [2:0] {
        SX_IDLE  = 3'd0,
        SX_START = 3'd1,
        SX_DATA  = 3'd2,
        SX_PAR   = 3'd3,
        SX_STOP  = 3'd4
    } sx_state_e;

endpackage

// File: rtl/sertx_fmt_decode.sv
module sertx_fmt_decode #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16,
    parameter int IDX_W  = $clog2(DATA_W) + 1,
    parameter int CNT_W  = $clog2(2 * OVS) + 1
) (
    input  logic [1:0]        len_code,
    input  logic              long_stop,
    input  logic              par_on,
    input  logic              par_even,
    input  logic              par_const,
    input  logic [DATA_W-1:0] data,
    output logic [IDX_W-1:0]  nbits,
    output logic              par_en,
    output logic              par_bit,
    output logic [CNT_W-1:0]  stop_ticks
);
    localparam int MIN_BITS = DATA_W - 3;

    logic [DATA_W-1:0] masked;

    assign nbits = IDX_W'(MIN_BITS) + IDX_W'(len_code);

    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign masked[i] = data[i] & (IDX_W'(i) < nbits);
    end

    always_comb begin
        logic ones_odd;
        ones_odd = ^masked;
        par_en   = par_on;
        if (par_const) begin
            par_bit = ~par_even;
        end else begin
            par_bit = par_even ? ones_odd : ~ones_odd;
        end
        if (!long_stop) begin
            stop_ticks = CNT_W'(OVS);
        end else if (len_code == 2'b00) begin
            stop_ticks = CNT_W'(OVS + OVS / 2);
        end else begin
            stop_ticks = CNT_W'(2 * OVS);
        end
    end

endmodule

// File: rtl/sertx_serializer.sv
module sertx_serializer
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16,
    parameter int IDX_W  = $clog2(DATA_W) + 1,
    parameter int CNT_W  = $clog2(2 * OVS) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic [IDX_W-1:0]  load_nbits,
    input  logic              load_par_en,
    input  logic              load_par_bit,
    input  logic [CNT_W-1:0]  load_stop_ticks,
    output logic              line,
    output logic              busy
);
    typedef struct packed {
        sx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] sh;
        logic [IDX_W-1:0]  nbits;
        logic              par_en;
        logic              par_bit;
        logic [CNT_W-1:0]  stop_ticks;
    } ser_reg_t;

    ser_reg_t r_q, r_d;

    always_comb begin
        logic last;
        r_d  = r_q;
        last = 1'b0;
        if (load && r_q.state == SX_IDLE) begin
            r_d.state      = SX_START;
            r_d.cnt        = '0;
            r_d.idx        = '0;
            r_d.sh         = load_data;
            r_d.nbits      = load_nbits;
            r_d.par_en     = load_par_en;
            r_d.par_bit    = load_par_bit;
            r_d.stop_ticks = load_stop_ticks;
        end else if (tick && r_q.state != SX_IDLE) begin
            if (r_q.state == SX_STOP) begin
                last = (r_q.cnt == r_q.stop_ticks - CNT_W'(1));
            end else begin
                last = (r_q.cnt == CNT_W'(OVS - 1));
            end
            if (!last) begin
                r_d.cnt = r_q.cnt + CNT_W'(1);
            end else begin
                r_d.cnt = '0;
                case (r_q.state)
                    SX_START: r_d.state = SX_DATA;
                    SX_DATA: begin
                        r_d.sh = r_q.sh >> 1;
                        if (r_q.idx == r_q.nbits - IDX_W'(1)) begin
                            r_d.state = r_q.par_en ? SX_PAR : SX_STOP;
                        end else begin
                            r_d.idx = r_q.idx + IDX_W'(1);
                        end
                    end
                    SX_PAR:  r_d.state = SX_STOP;
                    default: r_d.state = SX_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: SX_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (r_q.state)
            SX_START: line = 1'b0;
            SX_DATA:  line = r_q.sh[0];
            SX_PAR:   line = r_q.par_bit;
            default:  line = 1'b1;
        endcase
    end

    assign busy = (r_q.state != SX_IDLE);

    AST_START_IS_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$past(busy)) |-> !line); // R2

    AST_DATA_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == SX_DATA) |-> (r_q.idx < r_q.nbits)); // R2

    AST_STOP_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == SX_STOP) |-> (r_q.cnt < r_q.stop_ticks)); // R3

endmodule

// File: rtl/serial_tx_core.sv
module serial_tx_core #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              baud_x16,
    input  logic [6:0]        line_ctrl,
    output logic              txd,
    output logic              hold_empty,
    output logic              shift_empty
);
    localparam int IDX_W = $clog2(DATA_W) + 1;
    localparam int CNT_W = $clog2(2 * OVS) + 1;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              full;
    } hold_reg_t;

    hold_reg_t h_q, h_d;

    logic             ser_busy;
    logic             ser_line;
    logic             xfer;
    logic [IDX_W-1:0] dec_nbits;
    logic             dec_par_en;
    logic             dec_par_bit;
    logic [CNT_W-1:0] dec_stop_ticks;

    assign xfer = h_q.full && !ser_busy;

    always_comb begin
        h_d = h_q;
        if (wr_en) begin
            h_d.data = wr_data;
            h_d.full = 1'b1;
        end else if (xfer) begin
            h_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    sertx_fmt_decode #(
        .DATA_W(DATA_W), .OVS(OVS), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_decode (
        .len_code   (line_ctrl[1:0]),
        .long_stop  (line_ctrl[2]),
        .par_on     (line_ctrl[3]),
        .par_even   (line_ctrl[4]),
        .par_const  (line_ctrl[5]),
        .data       (h_q.data),
        .nbits      (dec_nbits),
        .par_en     (dec_par_en),
        .par_bit    (dec_par_bit),
        .stop_ticks (dec_stop_ticks)
    );

    sertx_serializer #(
        .DATA_W(DATA_W), .OVS(OVS), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_ser (
        .clk             (clk),
        .rst_n           (rst_n),
        .tick            (baud_x16),
        .load            (xfer),
        .load_data       (h_q.data),
        .load_nbits      (dec_nbits),
        .load_par_en     (dec_par_en),
        .load_par_bit    (dec_par_bit),
        .load_stop_ticks (dec_stop_ticks),
        .line            (ser_line),
        .busy            (ser_busy)
    );

    assign txd         = ser_line & ~line_ctrl[6];
    assign hold_empty  = ~h_q.full;
    assign shift_empty = ~ser_busy;

    AST_WRITE_FILLS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !hold_empty); // R8

    AST_HOLD_FREE_MEANS_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_empty) |-> !shift_empty); // R9

    AST_IDLE_LINE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_empty && !line_ctrl[6]) |-> txd); // R1

    AST_BREAK_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        line_ctrl[6] |-> !txd); // R7

endmodule

// File: tb/serial_tx_core_test.sv
module serial_tx_core_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       baud_x16 = 1'b0;
    logic [6:0] line_ctrl = 7'h03;
    logic       txd, hold_empty, shift_empty;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    serial_tx_core uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .baud_x16(baud_x16), .line_ctrl(line_ctrl),
        .txd(txd), .hold_empty(hold_empty), .shift_empty(shift_empty)
    );

    // {line_ctrl (bit 7 unused), data}
    localparam int NV = 11;
    localparam logic [15:0] VEC [NV] = '{
        16'h03_5A, // R2 8 bits, 1 stop
        16'h00_F3, // R2 5 bits, upper data bits dropped
        16'h19_2D, // R5 6 bits even parity
        16'h0E_55, // R3 R5 7 bits odd, 2 stop
        16'h0C_1F, // R3 5 bits odd, 1.5 stop
        16'h1F_81, // R3 R5 8 bits even, 2 stop
        16'h2B_00, // R6 constant parity 1
        16'h3A_7F, // R6 constant parity 0
        16'h33_A5, // R4 parity off, bits 4 and 5 set
        16'h05_3E, // R3 6 bits, 2 stop, no parity
        16'h0B_FF  // R5 8 bits odd
    };

    function automatic int exp_total(input logic [7:0] f);
        int nb, st;
        nb = 5 + int'(f[1:0]);
        st = f[2] ? ((nb == 5) ? 24 : 32) : 16;
        return 16 * (1 + nb + int'(f[3])) + st;
    endfunction

    function automatic logic exp_bit(input logic [7:0] f, input logic [7:0] d, input int j);
        int nb, b, ones;
        nb = 5 + int'(f[1:0]);
        b = j / 16;
        ones = 0;
        for (int i = 0; i < nb; i++) ones += int'(d[i]);
        if (b == 0) return 1'b0;
        if (b <= nb) return d[b-1];
        if (f[3] && b == nb + 1) begin
            if (f[5]) return ~f[4];
            return f[4] ? logic'(ones % 2) : logic'(1 - ones % 2);
        end
        return 1'b1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_byte(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Drives one tick per two clocks and compares txd at every tick.
    task automatic run_frame(input logic [7:0] f, input logic [7:0] d, input string req);
        int t, bad_j, bad_v;
        bit mism, se_ok;
        t = exp_total(f);
        mism = 1'b0;
        se_ok = 1'b1;
        bad_j = 0;
        bad_v = 0;
        for (int j = 0; j < t; j++) begin
            @(negedge clk);
            if (txd !== exp_bit(f, d, j) && !mism) begin
                mism = 1'b1;
                bad_j = j;
                bad_v = int'(txd);
            end
            if (shift_empty !== 1'b0) se_ok = 1'b0;
            baud_x16 = 1'b1;
            @(negedge clk);
            baud_x16 = 1'b0;
        end
        check(!mism, req, bad_v, int'(exp_bit(f, d, bad_j)));
        check(se_ok && shift_empty === 1'b1, "R9 shift_empty through stop end",
              int'(shift_empty), 1);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(txd === 1'b1 && hold_empty === 1'b1 && shift_empty === 1'b1,
              "R1 reset state", {txd, hold_empty, shift_empty}, 3'b111);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            line_ctrl = VEC[v][14:8];
            write_byte(VEC[v][7:0]);
            run_frame(VEC[v][15:8], VEC[v][7:0], "R2/R3/R4/R5/R6 frame waveform");
        end

        // R7 break while idle, then release
        line_ctrl = 7'h43;
        @(negedge clk);
        check(txd === 1'b0, "R7 break forces space", int'(txd), 0);
        check(shift_empty === 1'b1, "R7 break leaves serializer idle", int'(shift_empty), 1);
        line_ctrl = 7'h03;
        @(negedge clk);
        check(txd === 1'b1, "R7 line returns to mark", int'(txd), 1);

        // R8 R10 overwrite of a pending byte
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = 8'hC3;
        @(negedge clk);
        check(hold_empty === 1'b0, "R8 hold_empty falls on write", int'(hold_empty), 0);
        wr_data = 8'h11;               // lands in the same cycle as the transfer
        @(negedge clk);
        check(shift_empty === 1'b0, "R9 shift_empty falls on transfer", int'(shift_empty), 0);
        check(hold_empty === 1'b0, "R8 second byte pending", int'(hold_empty), 0);
        wr_data = 8'h96;               // overwrites 8'h11
        @(negedge clk);
        wr_en = 1'b0;
        run_frame(8'h03, 8'hC3, "R10 first frame");
        check(hold_empty === 1'b0, "R8 byte still pending at idle", int'(hold_empty), 0);
        run_frame(8'h03, 8'h96, "R10 last written byte sent");
        check(hold_empty === 1'b1, "R8 hold_empty after transfer", int'(hold_empty), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule